// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block watches a 64-bit multiplexed address/data bus split into two 32-bit lanes. Each lane has four active-low byte-enable/command lines and its own even parity bit. On every cycle it computes the parity of both lanes. The result is registered so it can be driven as the outgoing parity one clock later. When an address or data phase is flagged, the parity that arrives on the following cycle is compared against the computed value.

A mismatch turns into a one-clock error strobe. A mismatch in a data phase of an ordinary transaction pulses the active-low data-error output. A mismatch in an address phase, or in a data phase of a broadcast (special) transaction, goes to the system-error output instead. That output is modelled as an open-drain enable that only ever pulls low. The upper lane takes part in checking only when the 64-bit transfer flag is raised for the cycle it protects.

Top module: `busParityUnit`

## Requirements
- R1: `parOut` is registered so that, one clock after any cycle, `ad[31:0]`, `cbeN[3:0]` and `parOut` together hold an even number of ones.
- R2: `par64Out` is registered so that, one clock after any cycle, `ad[63:32]`, `cbeN[7:4]` and `par64Out` together hold an even number of ones.
- R3: The received `parIn`/`par64In` are compared on the cycle after the values they protect. A comparison happens only if `addrPhase` or `dataPhase` was high in the protected cycle. Wrong parity after an idle cycle has no effect.
- R4: The upper lane (`par64In` against `ad[63:32]`, `cbeN[7:4]`) is checked only when `wide64` was high in the protected cycle. Otherwise a wrong `par64In` is ignored.
- R5: A parity mismatch on an ordinary data phase drives `perrN` low for exactly one clock. The pulse follows the edge that samples the received parity, so it shows two clocks after the data cycle. `serrOe` stays low.
- R6: A parity mismatch on an address phase raises `serrOe` for exactly one clock, with the same timing as R5. `perrN` stays high.
- R7: The command of an address phase is `cbeN[3:0]`, and it is held until the next address phase. When the held command is 4'b0001 (broadcast), a data-phase mismatch raises `serrOe` instead of pulsing `perrN`.
- R8: Mismatches on both lanes in one cycle give a single one-clock report. Back-to-back erroneous phases give one report per clock, and `perrN` low never coincides with `serrOe` high.
- R9: When `addrPhase` and `dataPhase` are both high, the cycle is treated as an address phase.
- R10: While `rstN` is low, `perrN` is high, `serrOe` is low, both parity outputs are 0, and the held command is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrPhase | input | 1 | Current cycle is an address phase |
| dataPhase | input | 1 | Current cycle is a data phase |
| wide64 | input | 1 | Current cycle uses both lanes |
| ad | input | 64 | Multiplexed address/data lines |
| cbeN | input | 8 | Command / byte-enable lines, active low |
| parIn | input | 1 | Received parity of the lower lane |
| par64In | input | 1 | Received parity of the upper lane |
| parOut | output | 1 | Generated parity of the lower lane |
| par64Out | output | 1 | Generated parity of the upper lane |
| perrN | output | 1 | Data parity error strobe, active low |
| serrOe | output | 1 | System error pull-down enable |

## Verification
The assertions check every cycle that the generated parity bits make each lane even against the previous cycle's lines. They also check that an error strobe appears only after a staged phase of the matching kind, and that the two error outputs never fire together. Other behaviours need the bench's scenarios: the exact two-clock delay of a report, the suppression of upper-lane errors on 32-bit transfers, and the effect of a held broadcast command on a later data phase. The same holds for the priority of address over data phase and the silence after idle cycles with bad parity. A behavioural model in the bench predicts all four outputs on every clock.

// File: rtl/busParityPkg.sv
package busParityPkg;
  // Broadcast (special) command code as seen on cbeN[3:0] in an address phase
  localparam logic [3:0] BROADCAST_CMD = 4'b0001;

  // Compare strobes handed from control to datapath, aligned with received parity
  typedef struct packed {
    logic cmpEn;   // a phase was staged last cycle
    logic cmpHi;   // upper lanes take part
  } cmpStrobeT;
endpackage

// File: rtl/parityDatapath.sv
module parityDatapath
  import busParityPkg::*;
#(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANES*LANE_W-1:0]  ad,
  input  logic [LANES*BE_W-1:0]    cbeN,
  input  logic [LANES-1:0]         parRx,
  input  cmpStrobeT                strobe,
  output logic [LANES-1:0]         parGen,
  output logic [LANES-1:0]         laneBad
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic laneParity;
    assign laneParity = ^{ad[g*LANE_W +: LANE_W], cbeN[g*BE_W +: BE_W]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) parGen[g] <= 1'b0;
      else       parGen[g] <= laneParity;
    end

    logic laneEnabled;
    if (g == 0) begin : gLow
      assign laneEnabled = strobe.cmpEn;
    end else begin : gHigh
      assign laneEnabled = strobe.cmpEn && strobe.cmpHi;
    end

    assign laneBad[g] = laneEnabled && (parRx[g] != parGen[g]);

    // R1 for lane 0, R2 for the upper lane: even count one clock later
    assert_lane_even_R1: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> ((^{$past(ad[g*LANE_W +: LANE_W]), $past(cbeN[g*BE_W +: BE_W]), parGen[g]}) == 1'b0))
      else $error("lane %0d generated parity not even", g);
  end

endmodule

// File: rtl/parityControl.sv
module parityControl
  import busParityPkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrPhase,
  input  logic             dataPhase,
  input  logic             wide64,
  input  logic [3:0]       cmdCode,
  input  logic [LANES-1:0] laneBad,
  output cmpStrobeT        strobe,
  output logic             perrN,
  output logic             serrOe
);

  logic heldBroadcast;
  logic stAddr, stData, stHi, stBroadcast;
  logic anyBad;

  assign anyBad = |laneBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBroadcast <= 1'b0;
      stAddr        <= 1'b0;
      stData        <= 1'b0;
      stHi          <= 1'b0;
      stBroadcast   <= 1'b0;
      perrN         <= 1'b1;
      serrOe        <= 1'b0;
    end else begin
      // address phase wins when both flags are high
      stAddr      <= addrPhase;
      stData      <= dataPhase && !addrPhase;
      stHi        <= wide64;
      stBroadcast <= heldBroadcast;
      if (addrPhase) heldBroadcast <= (cmdCode == BROADCAST_CMD);
      perrN  <= !(anyBad && stData && !stBroadcast);
      serrOe <= anyBad && (stAddr || (stData && stBroadcast));
    end
  end

  always_comb begin
    strobe.cmpEn = stAddr || stData;
    strobe.cmpHi = stHi;
  end

  // R5: a data error strobe only follows a staged ordinary data phase
  assert_perr_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    !perrN |-> $past(stData && !stBroadcast))
    else $error("perrN pulse without ordinary data phase");

  // R6 / R7: system error only after an address phase or a broadcast data phase
  assert_serr_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> $past(stAddr || (stData && stBroadcast)))
    else $error("serrOe without address or broadcast phase");

  // R8: a single report per detected error, never on both outputs
  assert_single_report_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!perrN && serrOe))
    else $error("both error outputs active");

endmodule

// File: rtl/busParityUnit.sv
module busParityUnit
  import busParityPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CBE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrPhase,
  input  logic              dataPhase,
  input  logic              wide64,
  input  logic [DATA_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbeN,
  input  logic              parIn,
  input  logic              par64In,
  output logic              parOut,
  output logic              par64Out,
  output logic              perrN,
  output logic              serrOe
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int BE_W   = CBE_W / LANES;

  cmpStrobeT        strobe;
  logic [LANES-1:0] parGen;
  logic [LANES-1:0] laneBad;

  parityDatapath #(.LANE_W(LANE_W), .BE_W(BE_W), .LANES(LANES)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ad     (ad),
    .cbeN   (cbeN),
    .parRx  ({par64In, parIn}),
    .strobe (strobe),
    .parGen (parGen),
    .laneBad(laneBad)
  );

  parityControl #(.LANES(LANES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrPhase(addrPhase),
    .dataPhase(dataPhase),
    .wide64   (wide64),
    .cmdCode  (cbeN[3:0]),
    .laneBad  (laneBad),
    .strobe   (strobe),
    .perrN    (perrN),
    .serrOe   (serrOe)
  );

  assign parOut   = parGen[0];
  assign par64Out = parGen[1];

  // R10: outputs are quiet on the clock after reset is seen low
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (perrN && !serrOe))
    else $error("error outputs active after reset");

endmodule

// File: tb/tb_busParityUnit.sv
module tb_busParityUnit;
  logic clk = 1'b0;
  logic rstN;
  logic addrPhase, dataPhase, wide64;
  logic [63:0] ad;
  logic [7:0] cbeN;
  logic parIn, par64In;
  logic parOut, par64Out, perrN, serrOe;

  always #10 clk = ~clk;   // 50 MHz

  busParityUnit dut (
    .clk(clk), .rstN(rstN), .addrPhase(addrPhase), .dataPhase(dataPhase),
    .wide64(wide64), .ad(ad), .cbeN(cbeN), .parIn(parIn), .par64In(par64In),
    .parOut(parOut), .par64Out(par64Out), .perrN(perrN), .serrOe(serrOe)
  );

  typedef struct {
    logic a, d, w;
    logic [63:0] ad;
    logic [7:0] cb;
    logic pl, ph;
  } cycT;

  cycT h1, h2;
  logic specSt;
  int cmpCount = 0;
  int missCount = 0;
  bit done = 1'b0;
  string scen = "reset";

  task automatic check(input string tag, input string name, input logic act, input logic exp);
    cmpCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s [%s]: got %0b expected %0b", tag, name, scen, act, exp);
    end
  endtask

  // One bus cycle: compare model at negedge, then drive the next inputs
  task automatic step(input logic a, input logic d, input logic w,
                      input logic [63:0] adv, input logic [7:0] cb,
                      input logic flipLo, input logic flipHi);
    logic expPar, expPar64, mLo, mHi, bad, isAddr, isBc;
    cycT n;
    @(negedge clk);
    expPar   = ^{h1.ad[31:0],  h1.cb[3:0]};
    expPar64 = ^{h1.ad[63:32], h1.cb[7:4]};
    mLo = h1.pl != ^{h2.ad[31:0],  h2.cb[3:0]};
    mHi = h2.w && (h1.ph != ^{h2.ad[63:32], h2.cb[7:4]});
    bad = (h2.a || h2.d) && (mLo || mHi);
    isAddr = h2.a;
    isBc = !h2.a && h2.d && specSt;
    check("R1", "parOut", parOut, expPar);
    check("R2", "par64Out", par64Out, expPar64);
    check("R5", "perrN", perrN, !(bad && !isAddr && !isBc));
    check("R6", "serrOe", serrOe, bad && (isAddr || isBc));
    if (h2.a) specSt = (h2.cb[3:0] == 4'b0001);
    n.a = a; n.d = d; n.w = w; n.ad = adv; n.cb = cb;
    n.pl = (^{h1.ad[31:0],  h1.cb[3:0]}) ^ flipLo;
    n.ph = (^{h1.ad[63:32], h1.cb[7:4]}) ^ flipHi;
    addrPhase = a; dataPhase = d; wide64 = w; ad = adv; cbeN = cb;
    parIn = n.pl; par64In = n.ph;
    h2 = h1; h1 = n;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) step(0, 0, 0, 64'h0, 8'hFF, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, missCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addrPhase = 0; dataPhase = 0; wide64 = 0;
    ad = '0; cbeN = '0; parIn = 0; par64In = 0;
    h1 = '{default: '0}; h2 = '{default: '0}; specSt = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs while in reset
    check("R10", "perrN", perrN, 1'b1);
    check("R10", "serrOe", serrOe, 1'b0);
    check("R10", "parOut", parOut, 1'b0);
    check("R10", "par64Out", par64Out, 1'b0);
    rstN = 1'b1;

    scen = "clean 32-bit read";
    step(1, 0, 0, 64'h0000_0000_1000_0040, 8'hF6, 0, 0);
    step(0, 1, 0, 64'hDEAD_BEEF_CAFE_F00D, 8'hF0, 0, 0);
    step(0, 1, 0, 64'h1234_5678_9ABC_DEF0, 8'hF3, 0, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 0, 0);
    idle(3);

    scen = "R6 address error";
    step(1, 0, 0, 64'h0000_0000_2000_0000, 8'hF7, 0, 0);
    step(0, 1, 0, 64'h0000_0000_0000_00FF, 8'hF0, 1, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 0, 0);
    idle(3);

    scen = "R5 data error lower lane";
    step(1, 0, 0, 64'h0000_0000_3000_0000, 8'hF6, 0, 0);
    step(0, 1, 0, 64'h0000_0000_A5A5_A5A5, 8'hF0, 0, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 0);
    idle(3);

    scen = "R4 upper error on 64-bit transfer";
    step(1, 0, 1, 64'h0000_0001_4000_0000, 8'h06, 0, 0);
    step(0, 1, 1, 64'hFFFF_0000_1111_2222, 8'h00, 0, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 0, 1);
    idle(3);

    scen = "R4 upper ignored on 32-bit transfer";
    step(1, 0, 0, 64'h0000_0000_5000_0000, 8'h06, 0, 1);
    step(0, 1, 0, 64'h7777_0000_3333_4444, 8'h00, 0, 1);
    step(0, 0, 0, 64'h0, 8'hFF, 0, 1);
    idle(3);

    scen = "R7 broadcast data error";
    step(1, 0, 0, 64'h0, 8'hF1, 0, 0);
    step(0, 1, 0, 64'h0000_0000_0000_0001, 8'hF0, 0, 0);
    step(0, 1, 0, 64'h0000_0000_0000_0002, 8'hF0, 1, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 0);
    idle(3);
    scen = "R7 held command replaced";
    step(1, 0, 0, 64'h0000_0000_6000_0000, 8'hF7, 0, 0);
    step(0, 1, 0, 64'h0000_0000_0000_0003, 8'hF0, 0, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 0);
    idle(3);

    scen = "R8 both lanes bad, back to back";
    step(1, 0, 1, 64'h0000_0002_7000_0000, 8'h06, 0, 0);
    step(0, 1, 1, 64'h8888_9999_AAAA_BBBB, 8'h00, 0, 0);
    step(0, 1, 1, 64'hCCCC_DDDD_EEEE_FFFF, 8'h00, 1, 1);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 0);
    idle(3);

    scen = "R9 both phase flags";
    step(1, 1, 0, 64'h0000_0000_8000_0000, 8'hF6, 0, 0);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 0);
    idle(3);

    scen = "R3 idle with bad parity";
    step(0, 0, 1, 64'h0123_4567_89AB_CDEF, 8'h5A, 1, 1);
    step(0, 0, 1, 64'hFEDC_BA98_7654_3210, 8'hA5, 1, 1);
    step(0, 0, 0, 64'h0, 8'hFF, 1, 1);
    idle(3);

    scen = "R3 random traffic";
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ph;
      ph = 3'($urandom_range(0, 7));
      step(ph == 3'd0, ph >= 3'd2, 1'($urandom_range(0, 1)),
           {$urandom, $urandom}, 8'($urandom),
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
    end
    idle(4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, missCount);
    $finish;
  end
endmodule